// File: doc/BRIEF.md
# Frame-Sync and Clock Adapter

The adapter sits between a time-division multiplexed subscriber bus and a plain synchronous serial port. The bus carries a clock at twice the bit rate and marks each 8 kHz frame with a long strobe whose rising edge lines up with the first data bit. The serial port needs a clock at the bit rate and a sync pulse one bit wide that comes one bit before the first data bit of each word.

A frame position counter runs on the falling edge of the bus clock and restarts on the strobe's rising edge. Bit 0 of that counter is the port clock. A slot decoder raises a registered, one-bit-time sync pulse ahead of every byte slot whose bit is set in a slot mask. Terminal mode has 12 byte slots in 192 bus cycles. Line mode has 32 byte slots in 512 bus cycles. Receive data passes straight through. Transmit data drives the upstream line, and an output enable is computed for each bit from the slot mask and a mask of bit positions within the slot. This lets several transmitters share fields smaller than a byte.

No sync pulse and no output enable are produced until the first strobe after reset. A lock flag shows that a strobe has arrived exactly one frame length after the previous one. A strobe at any other count restarts the counter and sets a sticky misalignment flag.

Top module: `fsync_clk_adapter`

## Requirements
- R1: `port_clk_o` is half the bus clock rate. It is low while the frame position is even and high while it is odd. Position 0 is the bus cycle that starts at the falling edge where the strobe is first sampled high.
- R2: The frame position advances by one on each falling edge of the bus clock. With `line_mode_i`=0 it wraps after 191. With `line_mode_i`=1 it wraps after 511.
- R3: For an enabled byte slot b (the slot starting at position 16·b), `port_sync_o` is high for exactly the two bus cycles at positions 16·b−2 and 16·b−1, taken modulo the frame length. It is low at all other times.
- R4: Bit b of `slot_mask_i` enables byte slot b. In terminal mode only bits 0 to 11 are used, and bits 12 to 31 have no effect.
- R5: After reset, `port_sync_o` and `up_oe_o` stay low until the first rising edge of `frame_strobe_i`.
- R6: `locked_o` rises when a strobe rising edge arrives while the previous position is the last position of the frame. A strobe rising edge at any other position clears it. It stays low after the first strobe that follows reset.
- R7: A strobe rising edge at an unexpected position restarts the frame at position 0 and sets `misalign_o`. `misalign_o` stays set until reset.
- R8: `port_rx_o` equals `dn_data_i`, and `up_data_o` equals `port_tx_i`, with no delay.
- R9: Once started, `up_oe_o` is high at position p only when slot mask bit p/16 is set and bit (p mod 16)/2 of `oe_mask_i` is set.
- R10: While `rst_ni` is low, `port_sync_o`, `locked_o`, `misalign_o` and `up_oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_strobe_i | input | 1 | Long frame strobe, rising edge on the first bit |
| line_mode_i | input | 1 | 0: 12-slot terminal frame; 1: 32-slot line frame |
| slot_mask_i | input | 32 | Enable for each byte slot |
| oe_mask_i | input | 8 | Upstream drive enable for each bit position within a slot |
| dn_data_i | input | 1 | Downstream bus data |
| port_tx_i | input | 1 | Serial port transmit data |
| port_clk_o | output | 1 | Bit-rate clock to the serial port |
| port_sync_o | output | 1 | Sync pulse to the serial port, one bit time wide |
| port_rx_o | output | 1 | Receive data to the serial port |
| up_data_o | output | 1 | Upstream bus data |
| up_oe_o | output | 1 | Drive enable for the upstream tri-state buffer |
| locked_o | output | 1 | A strobe arrived exactly one frame after the previous one |
| misalign_o | output | 1 | Sticky flag: a strobe arrived at an unexpected position |

## Verification
The decoder is exercised with single-slot masks at the first slot, the last slot, a middle slot and the 12/13 slot boundary in line mode. This separates a wrong slot offset, a wrong wrap point and a wrong mode selection. The bench also uses full and sparse masks over whole frames in both modes, so a pulse that is too wide or lands one cycle off is seen anywhere in the frame. Bit-enable masks that select one bit position show whether the drive enable indexes the byte slot and the bit position correctly. Strobe sequences are an absent strobe, an aligned strobe and an early strobe, which separate the lock flag, the sticky misalignment flag and the counter restart.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  localparam int SLOT_CYC   = 16;
  localparam int TERM_SLOTS = 12;
  localparam int LINE_SLOTS = 32;
  localparam int TERM_LEN   = TERM_SLOTS * SLOT_CYC;
  localparam int LINE_LEN   = LINE_SLOTS * SLOT_CYC;
  localparam int CNT_W      = $clog2(LINE_LEN);
  localparam int OE_W       = SLOT_CYC / 2;
  localparam int SYNC_LEAD  = 2;  // bus cycles the pulse precedes the slot
endpackage

// File: rtl/fsa_frame_counter.sv
module fsa_frame_counter #(
  parameter int CNT_W    = fsa_pkg::CNT_W,
  parameter int TERM_LEN = fsa_pkg::TERM_LEN,
  parameter int LINE_LEN = fsa_pkg::LINE_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             line_mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             started_o,
  output logic             locked_o,
  output logic             misalign_o
);
  logic [CNT_W-1:0] cnt_q, last_c;
  logic strobe_q, rise, at_end;
  logic started_q, locked_q, misalign_q;

  assign last_c = line_mode_i ? CNT_W'(LINE_LEN - 1) : CNT_W'(TERM_LEN - 1);
  assign rise   = strobe_i & ~strobe_q;
  assign at_end = cnt_q >= last_c;

  // counter runs on the falling edge of the bus clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      strobe_q   <= 1'b0;
      started_q  <= 1'b0;
      locked_q   <= 1'b0;
      misalign_q <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      if (rise || at_end) cnt_q <= '0;
      else                cnt_q <= cnt_q + CNT_W'(1);
      if (rise) begin
        started_q <= 1'b1;
        if (started_q) begin
          if (cnt_q == last_c) locked_q <= 1'b1;
          else begin
            locked_q   <= 1'b0;
            misalign_q <= 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign started_o  = started_q;
  assign locked_o   = locked_q;
  assign misalign_o = misalign_q;

  AST_FS_RESTARTS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rise |=> (cnt_q == '0)); // R7
  AST_CNT_STEP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!rise && (cnt_q < last_c)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_MISALIGN_STICKY: assert property (@(negedge clk_i) disable iff (!rst_ni)
    misalign_q |=> misalign_q); // R7
  AST_LOCK_FULL_FRAME: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(cnt_q) == $past(last_c))); // R6
endmodule

// File: rtl/fsa_sync_decoder.sv
module fsa_sync_decoder #(
  parameter int CNT_W      = fsa_pkg::CNT_W,
  parameter int SLOT_CYC   = fsa_pkg::SLOT_CYC,
  parameter int TERM_SLOTS = fsa_pkg::TERM_SLOTS,
  parameter int LINE_SLOTS = fsa_pkg::LINE_SLOTS,
  parameter int LEAD       = fsa_pkg::SYNC_LEAD
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_mode_i,
  input  logic                  started_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [LINE_SLOTS-1:0] slot_mask_i,
  output logic                  sync_o
);
  localparam int TERM_LEN = TERM_SLOTS * SLOT_CYC;
  localparam int LINE_LEN = LINE_SLOTS * SLOT_CYC;

  logic [LINE_SLOTS-1:0] hit;
  logic sync_q;

  // decode one count early to absorb the output register
  for (genvar s = 0; s < LINE_SLOTS; s++) begin : g_slot
    localparam int L0 = (s * SLOT_CYC + LINE_LEN - LEAD - 1) % LINE_LEN;
    localparam int L1 = (L0 + 1) % LINE_LEN;
    logic line_hit, term_hit;
    assign line_hit = (cnt_i == CNT_W'(L0)) || (cnt_i == CNT_W'(L1));
    if (s < TERM_SLOTS) begin : g_term
      localparam int T0 = (s * SLOT_CYC + TERM_LEN - LEAD - 1) % TERM_LEN;
      localparam int T1 = (T0 + 1) % TERM_LEN;
      assign term_hit = (cnt_i == CNT_W'(T0)) || (cnt_i == CNT_W'(T1));
    end else begin : g_no_term
      assign term_hit = 1'b0;
    end
    assign hit[s] = slot_mask_i[s] & (line_mode_i ? line_hit : term_hit);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= started_i & (|hit);
  end

  assign sync_o = sync_q;

  AST_SYNC_HOLDS_TWO: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |=> sync_q); // R3
  AST_SYNC_NO_THIRD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (sync_q && $past(sync_q)) |=> !sync_q); // R3
  AST_SYNC_NEEDS_START: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !started_i |=> !sync_q); // R5
endmodule

// File: rtl/fsa_lane_enable.sv
module fsa_lane_enable #(
  parameter int CNT_W      = fsa_pkg::CNT_W,
  parameter int SLOT_CYC   = fsa_pkg::SLOT_CYC,
  parameter int LINE_SLOTS = fsa_pkg::LINE_SLOTS,
  parameter int OE_W       = fsa_pkg::OE_W
) (
  input  logic                  started_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [LINE_SLOTS-1:0] slot_mask_i,
  input  logic [OE_W-1:0]       oe_mask_i,
  output logic                  oe_o
);
  localparam int SB = $clog2(SLOT_CYC);
  localparam int IW = $clog2(LINE_SLOTS);
  localparam int BW = $clog2(OE_W);

  logic [IW-1:0] slot_idx;
  logic [BW-1:0] bit_idx;

  assign slot_idx = cnt_i[SB +: IW];
  assign bit_idx  = cnt_i[1 +: BW];  // two bus cycles per bit
  assign oe_o     = started_i & slot_mask_i[slot_idx] & oe_mask_i[bit_idx];
endmodule

// File: rtl/fsync_clk_adapter.sv
module fsync_clk_adapter #(
  parameter int SLOT_CYC   = fsa_pkg::SLOT_CYC,
  parameter int TERM_SLOTS = fsa_pkg::TERM_SLOTS,
  parameter int LINE_SLOTS = fsa_pkg::LINE_SLOTS,
  parameter int OE_W       = SLOT_CYC / 2
) (
  input  logic                  bus_clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_strobe_i,
  input  logic                  line_mode_i,
  input  logic [LINE_SLOTS-1:0] slot_mask_i,
  input  logic [OE_W-1:0]       oe_mask_i,
  input  logic                  dn_data_i,
  input  logic                  port_tx_i,
  output logic                  port_clk_o,
  output logic                  port_sync_o,
  output logic                  port_rx_o,
  output logic                  up_data_o,
  output logic                  up_oe_o,
  output logic                  locked_o,
  output logic                  misalign_o
);
  localparam int TERM_LEN = TERM_SLOTS * SLOT_CYC;
  localparam int LINE_LEN = LINE_SLOTS * SLOT_CYC;
  localparam int CNT_W    = $clog2(LINE_LEN);

  logic [CNT_W-1:0] cnt;
  logic started;

  fsa_frame_counter #(.CNT_W(CNT_W), .TERM_LEN(TERM_LEN), .LINE_LEN(LINE_LEN)) u_cnt (
    .clk_i      (bus_clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (frame_strobe_i),
    .line_mode_i(line_mode_i),
    .cnt_o      (cnt),
    .started_o  (started),
    .locked_o   (locked_o),
    .misalign_o (misalign_o)
  );

  fsa_sync_decoder #(.CNT_W(CNT_W), .SLOT_CYC(SLOT_CYC), .TERM_SLOTS(TERM_SLOTS),
                     .LINE_SLOTS(LINE_SLOTS), .LEAD(fsa_pkg::SYNC_LEAD)) u_dec (
    .clk_i      (bus_clk_i),
    .rst_ni     (rst_ni),
    .line_mode_i(line_mode_i),
    .started_i  (started),
    .cnt_i      (cnt),
    .slot_mask_i(slot_mask_i),
    .sync_o     (port_sync_o)
  );

  fsa_lane_enable #(.CNT_W(CNT_W), .SLOT_CYC(SLOT_CYC), .LINE_SLOTS(LINE_SLOTS),
                    .OE_W(OE_W)) u_oe (
    .started_i  (started),
    .cnt_i      (cnt),
    .slot_mask_i(slot_mask_i),
    .oe_mask_i  (oe_mask_i),
    .oe_o       (up_oe_o)
  );

  assign port_clk_o = cnt[0];
  assign port_rx_o  = dn_data_i;
  assign up_data_o  = port_tx_i;

  AST_PORT_CLK_HALF: assert property (@(negedge bus_clk_i) disable iff (!rst_ni)
    (cnt == $past(cnt) + CNT_W'(1)) |-> (port_clk_o != $past(port_clk_o))); // R1
endmodule

// File: tb/tb_fsync_clk_adapter.sv
module tb_fsync_clk_adapter;
  localparam int CLK_PERIOD = 10;

  logic        bus_clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_strobe = 1'b0;
  logic        line_mode = 1'b0;
  logic [31:0] slot_mask = '1;
  logic [7:0]  oe_mask = '1;
  logic        dn_data = 1'b0;
  logic        port_tx = 1'b0;
  logic port_clk, port_sync, port_rx, up_data, up_oe, locked, misalign;

  int n_chk = 0;
  int n_bad = 0;
  int pos_ref = 0;
  int flen = 192;
  bit done = 1'b0;

  // {line_mode, slot_mask, oe_mask, position, expected sync, expected oe}
  localparam logic [51:0] VECS [0:15] = '{
    {1'b0, 32'h0000_0001, 8'hFF, 9'd190, 1'b1, 1'b0},
    {1'b0, 32'h0000_0001, 8'hFF, 9'd191, 1'b1, 1'b0},
    {1'b0, 32'h0000_0001, 8'hFF, 9'd189, 1'b0, 1'b0},
    {1'b0, 32'h0000_0001, 8'hFF, 9'd0,   1'b0, 1'b1},
    {1'b0, 32'h0000_0800, 8'hFF, 9'd174, 1'b1, 1'b0},
    {1'b0, 32'h0000_0800, 8'hFF, 9'd176, 1'b0, 1'b1},
    {1'b0, 32'h0000_0800, 8'hFF, 9'd190, 1'b0, 1'b1},
    {1'b0, 32'h0000_0004, 8'h04, 9'd36,  1'b0, 1'b1},
    {1'b0, 32'h0000_0004, 8'h04, 9'd34,  1'b0, 1'b0},
    {1'b0, 32'h0000_0004, 8'h04, 9'd30,  1'b1, 1'b0},
    {1'b0, 32'hFFFF_F000, 8'hFF, 9'd190, 1'b0, 1'b0},
    {1'b1, 32'h8000_0000, 8'hFF, 9'd494, 1'b1, 1'b0},
    {1'b1, 32'h0000_0001, 8'hFF, 9'd510, 1'b1, 1'b0},
    {1'b1, 32'h0000_0001, 8'hFF, 9'd190, 1'b0, 1'b0},
    {1'b1, 32'h0000_1000, 8'hFF, 9'd190, 1'b1, 1'b0},
    {1'b1, 32'h0000_1000, 8'hFF, 9'd200, 1'b0, 1'b1}
  };

  fsync_clk_adapter dut (
    .bus_clk_i     (bus_clk),
    .rst_ni        (rst_ni),
    .frame_strobe_i(frame_strobe),
    .line_mode_i   (line_mode),
    .slot_mask_i   (slot_mask),
    .oe_mask_i     (oe_mask),
    .dn_data_i     (dn_data),
    .port_tx_i     (port_tx),
    .port_clk_o    (port_clk),
    .port_sync_o   (port_sync),
    .port_rx_o     (port_rx),
    .up_data_o     (up_data),
    .up_oe_o       (up_oe),
    .locked_o      (locked),
    .misalign_o    (misalign)
  );

  always #(CLK_PERIOD / 2) bus_clk = ~bus_clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at pos %0d: actual %0d expected %0d", req, what, pos_ref, act, exp);
    end
  endtask

  // drive and sample one time unit after the rising edge, away from the active falling edge
  task automatic tick();
    @(posedge bus_clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    frame_strobe = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
  endtask

  task automatic begin_frame();
    frame_strobe = 1'b1;
    tick();
    pos_ref = 0;
  endtask

  task automatic step();
    int nxt;
    nxt = (pos_ref + 1) % flen;
    frame_strobe = (nxt < 4);
    tick();
    pos_ref = nxt;
  endtask

  function automatic int exp_sync(int p);
    return (((p % 16) >= 14) && slot_mask[((p + 2) % flen) / 16]) ? 1 : 0;
  endfunction

  function automatic int exp_oe(int p);
    return (slot_mask[p / 16] && oe_mask[(p % 16) / 2]) ? 1 : 0;
  endfunction

  task automatic scan(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      step();
      check("R1", "port_clk", port_clk, pos_ref % 2);
      check("R3", "port_sync", port_sync, exp_sync(pos_ref));
      check("R9", "up_oe", up_oe, exp_oe(pos_ref));
    end
  endtask

  initial begin
    repeat (200000) @(posedge bus_clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       lm, es, eo;
    logic [31:0] mk;
    logic [7:0] om;
    logic [8:0] vp;
    int hi_sync, hi_oe;

    // R10: outputs held in reset
    #1;
    check("R10", "port_sync", port_sync, 0);
    check("R10", "locked", locked, 0);
    check("R10", "misalign", misalign, 0);
    check("R10", "up_oe", up_oe, 0);

    // R5: no strobe yet, nothing emitted
    line_mode = 1'b0; flen = 192; slot_mask = '1; oe_mask = '1;
    do_reset();
    hi_sync = 0; hi_oe = 0;
    for (int i = 0; i < 600; i++) begin
      tick();
      hi_sync += int'(port_sync);
      hi_oe   += int'(up_oe);
    end
    check("R5", "sync count before strobe", hi_sync, 0);
    check("R5", "oe count before strobe", hi_oe, 0);

    // R1 R2 R3 R9: full terminal frames, all slots
    begin_frame();
    check("R1", "port_clk", port_clk, 0);
    check("R6", "locked after first strobe", locked, 0);
    scan(191);
    check("R6", "locked before frame end", locked, 0);
    scan(1);
    check("R2", "wrap to position 0 via clk", port_clk, 0);
    check("R6", "locked after aligned strobe", locked, 1);
    check("R7", "misalign after aligned strobe", misalign, 0);
    // R4 R3: sparse mask over a full frame
    slot_mask = 32'h0000_0A41; oe_mask = 8'h81;
    scan(192);

    // R8: data pass-through
    dn_data = 1'b1; port_tx = 1'b0; #1;
    check("R8", "port_rx", port_rx, 1);
    check("R8", "up_data", up_data, 0);
    dn_data = 1'b0; port_tx = 1'b1; #1;
    check("R8", "port_rx", port_rx, 0);
    check("R8", "up_data", up_data, 1);

    // R7: early strobe restarts the frame
    slot_mask = '1; oe_mask = '1;
    while (pos_ref != 100) step();
    frame_strobe = 1'b1;
    tick();
    pos_ref = 0;
    check("R7", "misalign set", misalign, 1);
    check("R6", "locked cleared", locked, 0);
    check("R7", "port_clk after restart", port_clk, 0);
    while (pos_ref != 190) step();
    check("R7", "sync follows restarted frame", port_sync, 1);
    scan(2);
    check("R6", "relock after aligned strobe", locked, 1);
    check("R7", "misalign sticky", misalign, 1);

    // R10: reset clears the sticky flag
    rst_ni = 1'b0; #1;
    check("R10", "misalign in reset", misalign, 0);
    check("R10", "locked in reset", locked, 0);

    // R2 R3 R4 R9: line mode full frame
    line_mode = 1'b1; flen = 512; slot_mask = 32'h8000_1001; oe_mask = 8'h81;
    do_reset();
    begin_frame();
    scan(512);
    check("R2", "line mode wraps at 512", pos_ref, 0);

    // R3 R4 R9: vector table
    for (int v = 0; v < 16; v++) begin
      {lm, mk, om, vp, es, eo} = VECS[v];
      line_mode = lm; slot_mask = mk; oe_mask = om;
      flen = lm ? 512 : 192;
      do_reset();
      begin_frame();
      while (pos_ref != int'(vp)) step();
      check("R3/R4", $sformatf("vector %0d sync", v), port_sync, int'(es));
      check("R9", $sformatf("vector %0d oe", v), up_oe, int'(eo));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule